// File: doc/BRIEF.md
# Bypass Policy Dueling Selector

This block decides, for every cache set touched by a lookup, which fill policy the last-level cache should apply to it. A fixed scattering of set indices is reserved as two small leader groups: one group always runs the baseline trip-count age-insertion policy, the other always runs the competing bypass policy. Every other set is a follower and copies whichever of the two is currently doing better for the requesting thread.

The score is kept in one saturating counter per thread. A miss in a baseline leader set raises that thread's counter and a miss in a bypass leader set lowers it, so the counter drifts toward the policy with fewer misses. While the counter's top bit is one, followers of that thread may bypass; otherwise they fall back to static insertion ages taken from trip count and use count, with no bypass. The replacement and insertion logic consuming the decision lies outside this block.

A lookup presents a set index and thread number; one clock later the block returns the set's role and a single bypass-enable bit. Miss reports arrive on a separate port and may coincide with lookups.

Top module: `set_duel_selector`

## Requirements
- R1: Reset is synchronous and active high; while it is held and in the cycle after, out_valid is 0, out_role is 0 and out_bypass is 0; every thread's counter restarts at its midpoint (512 for the 10-bit default), so a follower lookup right after reset returns out_bypass = 1.
- R2: A set whose index bits [9:6] equal bits [3:0], with bit 5 = 0 and bit 4 = 0, is a baseline leader and is reported with out_role = 1.
- R3: A set whose bits [9:6] equal bits [3:0], with bit 5 = 1 and bit 4 = 0, is a bypass leader and is reported with out_role = 2.
- R4: Every other index, including a matching key with bit 4 = 1, is a follower and is reported with out_role = 0; out_role is never 3.
- R5: A baseline leader lookup always returns out_bypass = 0 and a bypass leader lookup always returns out_bypass = 1, whatever the counters hold.
- R6: A follower lookup returns out_bypass equal to the top bit of the requesting thread's counter.
- R7: A miss in a baseline leader set adds one to the missing thread's counter, a miss in a bypass leader set subtracts one, and a miss in a follower set leaves every counter unchanged.
- R8: A counter at its maximum (1023) stays there on a further baseline leader miss, and a counter at 0 stays there on a further bypass leader miss.
- R9: Each thread's counter changes only on misses reported with that thread number; lookups for one thread never see another thread's score.
- R10: out_valid is lookup_valid delayed by one clock, and the result of a lookup uses the counter value from before any miss reported in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | A lookup is presented this cycle |
| lookup_set | input | 10 | Low bits of the looked-up set index |
| lookup_tid | input | 2 | Thread issuing the lookup |
| miss_valid | input | 1 | A miss is reported this cycle |
| miss_set | input | 10 | Low bits of the set index that missed |
| miss_tid | input | 2 | Thread that missed |
| out_valid | output | 1 | Registered result valid |
| out_role | output | 2 | 0 follower, 1 baseline leader, 2 bypass leader |
| out_bypass | output | 1 | 1 when bypass may be applied to this fill |

## Verification
A lookup and a leader miss of the same thread can fall in the same cycle, so the policy read and the counter update collide. The bench provokes this with a directed case where the counter sits exactly at the midpoint and a bypass leader miss arrives together with a follower lookup, expecting the old top bit in the result and the new one on the next lookup. Randomized traffic then mixes lookups and misses of all three set kinds on shared threads every cycle, judged against a bench model that reads the score before applying that cycle's miss.

// File: rtl/duel_pkg.sv
package duel_pkg;
  typedef enum logic [1:0] {
    ROLE_FOLLOW  = 2'd0,
    ROLE_OBSERVE = 2'd1,
    ROLE_SAMPLE  = 2'd2
  } set_role_e;
endpackage

// File: rtl/set_role_decoder.sv
module set_role_decoder
  import duel_pkg::*;
#(
  parameter int GROUP_W = 10
) (
  input  logic [GROUP_W-1:0] idx,
  output set_role_e          role
);
  localparam int KEY_W = (GROUP_W - 2) / 2;

  logic [KEY_W-1:0] key_hi;
  logic [KEY_W-1:0] key_lo;
  logic             pick_bit;
  logic             pad_bit;

  assign key_hi   = idx[GROUP_W-1 -: KEY_W];
  assign key_lo   = idx[KEY_W-1:0];
  assign pick_bit = idx[KEY_W+1];
  assign pad_bit  = idx[KEY_W];

  always_comb begin
    role = ROLE_FOLLOW;
    if (key_hi == key_lo && !pad_bit) begin
      role = pick_bit ? ROLE_SAMPLE : ROLE_OBSERVE;
    end
  end
endmodule

// File: rtl/duel_counter_bank.sv
module duel_counter_bank
  import duel_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int CNT_W   = 10,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     miss_valid,
  input  set_role_e                miss_role,
  input  logic [TID_W-1:0]         miss_tid,
  output logic [THREADS*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [CNT_W-1:0] score;
    logic             mine;

    assign mine = miss_valid && (miss_tid == TID_W'(t));

    always_ff @(posedge clk) begin
      if (rst) begin
        score <= CNT_MID;
      end else if (mine) begin
        if (miss_role == ROLE_OBSERVE && score != CNT_MAX) begin
          score <= score + 1'b1;
        end else if (miss_role == ROLE_SAMPLE && score != CNT_MIN) begin
          score <= score - 1'b1;
        end
      end
    end

    assign cnt_flat[t*CNT_W +: CNT_W] = score;
  end
endmodule

// File: rtl/set_duel_selector.sv
module set_duel_selector
  import duel_pkg::*;
#(
  parameter int GROUP_W = 10,
  parameter int THREADS = 4,
  parameter int CNT_W   = 10,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lookup_valid,
  input  logic [GROUP_W-1:0] lookup_set,
  input  logic [TID_W-1:0]   lookup_tid,
  input  logic               miss_valid,
  input  logic [GROUP_W-1:0] miss_set,
  input  logic [TID_W-1:0]   miss_tid,
  output logic               out_valid,
  output logic [1:0]         out_role,
  output logic               out_bypass
);
  set_role_e                lk_role;
  set_role_e                ms_role;
  logic [THREADS*CNT_W-1:0] cnt_flat;
  logic [THREADS-1:0]       bypass_wins;
  logic                     nxt_bypass;

  set_role_decoder #(.GROUP_W(GROUP_W)) u_lk_dec (
    .idx  (lookup_set),
    .role (lk_role)
  );

  set_role_decoder #(.GROUP_W(GROUP_W)) u_ms_dec (
    .idx  (miss_set),
    .role (ms_role)
  );

  duel_counter_bank #(.THREADS(THREADS), .CNT_W(CNT_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .miss_valid (miss_valid),
    .miss_role  (ms_role),
    .miss_tid   (miss_tid),
    .cnt_flat   (cnt_flat)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_win
    assign bypass_wins[t] = cnt_flat[t*CNT_W + CNT_W - 1];
  end

  always_comb begin
    unique case (lk_role)
      ROLE_OBSERVE: nxt_bypass = 1'b0;
      ROLE_SAMPLE:  nxt_bypass = 1'b1;
      default:      nxt_bypass = bypass_wins[lookup_tid];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_role   <= 2'd0;
      out_bypass <= 1'b0;
    end else begin
      out_valid  <= lookup_valid;
      out_role   <= lookup_valid ? 2'(lk_role) : 2'd0;
      out_bypass <= lookup_valid ? nxt_bypass : 1'b0;
    end
  end
endmodule

// File: rtl/duel_checker.sv
module duel_checker #(
  parameter int THREADS = 4,
  parameter int CNT_W   = 10
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     lookup_valid,
  input logic                     out_valid,
  input logic [1:0]               out_role,
  input logic                     out_bypass,
  input logic [THREADS*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CMIN = '0;

  logic [CNT_W-1:0] c0;
  assign c0 = cnt_flat[CNT_W-1:0];

  a_r10_valid_on: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> out_valid);
  a_r10_valid_off: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> !out_valid);
  a_r4_no_role3: assert property (@(posedge clk) disable iff (rst)
    out_role != 2'd3);
  a_r5_observer_no_bypass: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_role == 2'd1) |-> !out_bypass);
  a_r5_sample_bypass: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_role == 2'd2) |-> out_bypass);
  a_r8_no_wrap_high: assert property (@(posedge clk) disable iff (rst)
    (c0 == CMAX) |=> (c0 != CMIN));
  a_r8_no_wrap_low: assert property (@(posedge clk) disable iff (rst)
    (c0 == CMIN) |=> (c0 != CMAX));
  a_r7_unit_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (c0 == $past(c0) || c0 == $past(c0) + CNT_W'(1)
              || c0 == $past(c0) - CNT_W'(1)));
endmodule

bind set_duel_selector duel_checker #(.THREADS(THREADS), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lookup_valid (lookup_valid),
  .out_valid    (out_valid),
  .out_role     (out_role),
  .out_bypass   (out_bypass),
  .cnt_flat     (cnt_flat)
);

// File: tb/sim_set_duel_selector.sv
`timescale 1ns/1ps
module sim_set_duel_selector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lookup_valid = 1'b0;
  logic [9:0] lookup_set = '0;
  logic [1:0] lookup_tid = '0;
  logic       miss_valid = 1'b0;
  logic [9:0] miss_set = '0;
  logic [1:0] miss_tid = '0;
  logic       out_valid;
  logic [1:0] out_role;
  logic       out_bypass;

  int errors = 0;
  int checks = 0;
  int mcnt [4];
  bit done = 0;

  always #4 clk = ~clk;

  set_duel_selector u0 (
    .clk(clk), .rst(rst),
    .lookup_valid(lookup_valid), .lookup_set(lookup_set), .lookup_tid(lookup_tid),
    .miss_valid(miss_valid), .miss_set(miss_set), .miss_tid(miss_tid),
    .out_valid(out_valid), .out_role(out_role), .out_bypass(out_bypass)
  );

  function automatic int role_of(logic [9:0] s);
    if (s[9:6] == s[3:0] && !s[4]) return s[5] ? 2 : 1;
    return 0;
  endfunction

  function automatic logic [9:0] obs_set(logic [3:0] k);
    return {k, 2'b00, k};
  endfunction

  function automatic logic [9:0] smp_set(logic [3:0] k);
    return {k, 2'b10, k};
  endfunction

  function automatic logic [9:0] fol_set();
    logic [9:0] s = 10'($urandom);
    if (role_of(s) != 0) s[4] = 1'b1;
    return s;
  endfunction

  function automatic string req_of(int r);
    if (r == 1) return "R2/R5";
    if (r == 2) return "R3/R5";
    return "R4/R6";
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit lv, logic [9:0] ls, logic [1:0] lt,
                      bit mv, logic [9:0] ms, logic [1:0] mt, string req);
    int er, eb, mr;
    @(negedge clk);
    lookup_valid = lv; lookup_set = ls; lookup_tid = lt;
    miss_valid = mv; miss_set = ms; miss_tid = mt;
    er = role_of(ls);
    eb = (er == 1) ? 0 : (er == 2) ? 1 : ((mcnt[lt] >= 512) ? 1 : 0);
    @(posedge clk);
    #1;
    check({"R10 valid ", req}, int'(out_valid), int'(lv));
    if (lv) begin
      check({req, " role"}, int'(out_role), er);
      check({req, " bypass"}, int'(out_bypass), eb);
    end
    if (mv) begin
      mr = role_of(ms);
      if (mr == 1 && mcnt[mt] < 1023) mcnt[mt]++;
      if (mr == 2 && mcnt[mt] > 0) mcnt[mt]--;
    end
    lookup_valid = 0; miss_valid = 0;
  endtask

  task automatic miss_only(logic [9:0] ms, logic [1:0] mt, int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 1, ms, mt, "R7");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int t = 0; t < 4; t++) mcnt[t] = 512;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset role", int'(out_role), 0);
    check("R1 reset bypass", int'(out_bypass), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1: midpoint score lets followers bypass
    step(1, fol_set(), 0, 0, '0, 0, "R1 midpoint");
    // R2, R3, R4, R5 classification
    step(1, obs_set(4'h5), 1, 0, '0, 0, "R2/R5 observer");
    step(1, smp_set(4'hA), 1, 0, '0, 0, "R3/R5 sample");
    step(1, {4'h3, 2'b01, 4'h3}, 1, 0, '0, 0, "R4 pad bit follower");
    step(1, {4'h3, 2'b11, 4'h3}, 2, 0, '0, 0, "R4 pad bit follower");
    step(1, 10'h3FF, 3, 0, '0, 0, "R4 all ones");
    // R10: same-cycle lookup and miss, lookup sees old score
    step(1, fol_set(), 0, 1, smp_set(4'h2), 0, "R10 collision");
    step(1, fol_set(), 0, 0, '0, 0, "R6/R7 after decrement");
    step(1, fol_set(), 1, 0, '0, 0, "R9 other thread");
    // R7: follower misses leave score unchanged
    miss_only(fol_set(), 0, 10);
    step(1, fol_set(), 0, 1, obs_set(4'h0), 0, "R7 follower miss no effect");
    step(1, fol_set(), 0, 0, '0, 0, "R7 increment");
    // R8: low saturation on thread 2
    miss_only(smp_set(4'h1), 2, 600);
    miss_only(obs_set(4'h1), 2, 511);
    step(1, fol_set(), 2, 0, '0, 0, "R8 low saturation");
    miss_only(obs_set(4'h1), 2, 1);
    step(1, fol_set(), 2, 0, '0, 0, "R8 low saturation");
    // R8: high saturation on thread 3
    miss_only(obs_set(4'h7), 3, 600);
    miss_only(smp_set(4'h7), 3, 511);
    step(1, fol_set(), 3, 0, '0, 0, "R8 high saturation");
    miss_only(smp_set(4'h7), 3, 1);
    step(1, fol_set(), 3, 0, '0, 0, "R8 high saturation");
    step(1, obs_set(4'h9), 3, 0, '0, 3, "R5 observer ignores score");
    step(1, smp_set(4'h9), 2, 0, '0, 2, "R5 sample ignores score");

    // randomized mixture
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] ls, ms;
      int kl = $urandom % 3;
      int km = $urandom % 3;
      ls = (kl == 0) ? fol_set() : (kl == 1) ? obs_set(4'($urandom)) : smp_set(4'($urandom));
      ms = (km == 0) ? fol_set() : (km == 1) ? obs_set(4'($urandom)) : smp_set(4'($urandom));
      step(bit'($urandom % 4 != 0), ls, 2'($urandom), bit'($urandom % 2),
           ms, 2'($urandom), req_of(role_of(ls)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule